// File: doc/BRIEF.md
# Queue-Threshold Burst Redirector

This block steers packets for the output ports of a switch. Each packet descriptor carries a port, a flow ID and a byte length. For each one the block picks a destination: the port's local output queue, an upward path to an external deep buffer, a separate capped queue for long flows, or a drop. The choice depends on the queue depth each port reports, on a per-port redirect rule and on per-flow byte totals.

A port's redirect rule switches on as soon as its local queue depth rises above a redirect threshold. The rule only takes effect from the next cycle. The gap between that threshold and the hard queue limit is headroom for the packets that arrive in the meantime. The rule stays on until the local queue is back at or under the threshold and the port's deep-buffer copy has drained. A flow whose byte total passes a long-flow threshold is promoted for good. Its packets then bypass the redirect and go to the long-flow queue, which is capped below the redirect threshold.

Two token buckets per port limit the rates. Upward traffic is limited to twice the port rate. Returning traffic from the deep buffer is paced at the port rate. That returning traffic is the high-priority class at the output, so its acceptance signal is the only thing the block gives it.

Top module: `burst_redirector`

## Requirements
- R1: When a port's reported depth is strictly above REDIR_TH, its redirect rule is on from the next cycle. A packet seen in the cycle the depth first crosses is still steered by the old rule state.
- R2: A packet that is not from a long flow, for a port whose rule is off, goes to the local queue (code 0) if the port depth is below Q_LIMIT, and is dropped (code 3) otherwise.
- R3: A port's redirect rule switches off only when the depth is at or below REDIR_TH and that port's buffer-empty flag is high. It stays on while the flag is low.
- R4: Each flow sums the lengths of all its packets, saturating. The flow is long from the cycle after its total exceeds LF_BYTES, and it stays long. The packet that makes the total cross the threshold is not itself treated as long.
- R5: A packet from a long flow goes to the long-flow queue (code 2) if that port's long-flow depth is below LF_CAP, whatever the redirect rule says. Otherwise it is dropped (code 3).
- R6: A packet that is not from a long flow, for a port whose rule is on, goes upward (code 1) if that port's upward bucket holds at least the packet length, which is then charged. Otherwise it is dropped (code 3). The upward bucket refills by 2*RATE per cycle up to 2*BURST.
- R7: A downward request is accepted in the same cycle if its port's downward bucket holds at least its length, which is then charged. The downward bucket refills by RATE per cycle up to BURST. Refill is applied after the charge and then clamped.
- R8: After reset all redirect rules and long-flow flags are clear, both buckets of every port are full, and no decision is valid.
- R9: A decision appears on dec_valid/dec_dest exactly one cycle after the packet is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_depth | input | NUM_PORTS*DEPTH_W | Local queue depth per port, port 0 in the low bits |
| lf_depth | input | NUM_PORTS*DEPTH_W | Long-flow queue depth per port |
| buf_empty | input | NUM_PORTS | Deep-buffer drained flag per port |
| pkt_valid | input | 1 | Packet descriptor present |
| pkt_port | input | PORT_W | Destination port of the packet |
| pkt_flow | input | FLOW_W | Flow ID of the packet |
| pkt_len | input | LEN_W | Packet length in bytes |
| dn_valid | input | 1 | Downward packet from the deep buffer requests sending |
| dn_port | input | PORT_W | Port of the downward packet |
| dn_len | input | LEN_W | Length of the downward packet |
| dec_valid | output | 1 | Steering decision valid |
| dec_dest | output | 2 | 0 local, 1 upward, 2 long-flow queue, 3 drop |
| dn_accept | output | 1 | Downward packet may be sent this cycle |
| redirect_on | output | NUM_PORTS | Per-port redirect rule state |
| long_flow | output | NUM_FLOWS | Per-flow long-flow promotion state |

## Verification
The bench builds the block with four ports, eight flows, LEN_W of 11, a long-flow threshold of 3000 bytes, RATE of 64 and BURST of 2048. With these values three or four packets are enough to promote a flow. A short run of 1500-byte packets empties an upward bucket, and two 2000-byte downward requests empty a downward bucket, so the refusal paths get hit many times. The queue thresholds are kept at the example values of 100, 80 and 50. Random depths around those values reach the headroom cycle, the hard-limit drop and the cap on the long-flow queue.

// File: rtl/burst_redirector_pkg.sv
package burst_redirector_pkg;
   typedef enum logic [1:0] {
      DST_LOCAL = 2'd0,
      DST_UP    = 2'd1,
      DST_LONG  = 2'd2,
      DST_DROP  = 2'd3
   } steer_e;
endpackage

// File: rtl/rdr_token_bucket.sv
module rdr_token_bucket #(
   parameter int RATE  = 128,
   parameter int MAX   = 16384,
   parameter int LEN_W = 14,
   parameter int TOK_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [LEN_W-1:0] len,
   output logic             ok
);
   logic [TOK_W-1:0] tok;
   logic [TOK_W:0]   after_q, fill;

   if (MAX < (1 << LEN_W) - 1) begin : g_bad_max
      $error("bucket depth must hold the largest packet");
   end

   assign ok      = ({1'b0, tok} >= (TOK_W+1)'(len));
   assign after_q = {1'b0, tok} - ((take && ok) ? (TOK_W+1)'(len) : '0);
   assign fill    = after_q + (TOK_W+1)'(RATE);

   always_ff @(posedge clk) begin
      if (!rst_n)                        tok <= TOK_W'(MAX);
      else if (fill > (TOK_W+1)'(MAX))   tok <= TOK_W'(MAX);
      else                               tok <= fill[TOK_W-1:0];
   end

   // R6 / R7: a refused request leaves the bucket uncharged
   p_no_charge_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !ok) |=> (tok >= $past(tok)));
endmodule

// File: rtl/rdr_port_rule.sv
module rdr_port_rule #(
   parameter int DEPTH_W  = 10,
   parameter int REDIR_TH = 80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] depth,
   input  logic               drained,
   output logic               on
);
   logic above;
   assign above = (depth > DEPTH_W'(REDIR_TH));

   always_ff @(posedge clk) begin
      if (!rst_n)        on <= 1'b0;
      else if (above)    on <= 1'b1;
      else if (drained)  on <= 1'b0;
   end

   p_set_above_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (depth > DEPTH_W'(REDIR_TH)) |=> on);
   p_clear_needs_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(on) |-> $past(drained));
endmodule

// File: rtl/rdr_flow_meter.sv
module rdr_flow_meter #(
   parameter int NUM_FLOWS = 64,
   parameter int FLOW_W    = 6,
   parameter int LEN_W     = 14,
   parameter int LF_BYTES  = 50000,
   parameter int CNT_W     = 17
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid,
   input  logic [FLOW_W-1:0]    flow,
   input  logic [LEN_W-1:0]     len,
   output logic [NUM_FLOWS-1:0] long_o
);
   localparam logic [CNT_W-1:0] SAT = '1;

   for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_flow
      logic [CNT_W-1:0] cnt;
      logic [CNT_W:0]   sum;
      assign sum       = {1'b0, cnt} + (CNT_W+1)'(len);
      assign long_o[f] = (cnt > CNT_W'(LF_BYTES));

      always_ff @(posedge clk) begin
         if (!rst_n) cnt <= '0;
         else if (valid && flow == FLOW_W'(f))
            cnt <= sum[CNT_W] ? SAT : sum[CNT_W-1:0];
      end

      p_long_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
         long_o[f] |=> long_o[f]);
   end
endmodule

// File: rtl/burst_redirector.sv
module burst_redirector
   import burst_redirector_pkg::*;
#(
   parameter int NUM_PORTS = 8,
   parameter int NUM_FLOWS = 64,
   parameter int DEPTH_W   = 10,
   parameter int Q_LIMIT   = 100,
   parameter int REDIR_TH  = 80,
   parameter int LF_CAP    = 50,
   parameter int LF_BYTES  = 50000,
   parameter int LEN_W     = 14,
   parameter int RATE      = 128,
   parameter int BURST     = 16384,
   localparam int PORT_W   = $clog2(NUM_PORTS),
   localparam int FLOW_W   = $clog2(NUM_FLOWS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_PORTS*DEPTH_W-1:0] q_depth,
   input  logic [NUM_PORTS*DEPTH_W-1:0] lf_depth,
   input  logic [NUM_PORTS-1:0]         buf_empty,
   input  logic                         pkt_valid,
   input  logic [PORT_W-1:0]            pkt_port,
   input  logic [FLOW_W-1:0]            pkt_flow,
   input  logic [LEN_W-1:0]             pkt_len,
   input  logic                         dn_valid,
   input  logic [PORT_W-1:0]            dn_port,
   input  logic [LEN_W-1:0]             dn_len,
   output logic                         dec_valid,
   output logic [1:0]                   dec_dest,
   output logic                         dn_accept,
   output logic [NUM_PORTS-1:0]         redirect_on,
   output logic [NUM_FLOWS-1:0]         long_flow
);
   localparam int UP_RATE  = 2 * RATE;
   localparam int UP_BURST = 2 * BURST;
   localparam int TOK_W    = $clog2(UP_BURST + UP_RATE + 1) + 1;
   localparam int CNT_W    = $clog2(LF_BYTES + 1) + 1;

   if (NUM_PORTS < 2 || NUM_FLOWS < 2) begin : g_bad_count
      $error("need at least two ports and two flows");
   end
   if (!(LF_CAP < REDIR_TH && REDIR_TH < Q_LIMIT)) begin : g_bad_order
      $error("thresholds must satisfy LF_CAP < REDIR_TH < Q_LIMIT");
   end
   if (Q_LIMIT >= (1 << DEPTH_W)) begin : g_bad_depth
      $error("Q_LIMIT does not fit DEPTH_W");
   end

   logic [DEPTH_W-1:0]   dep_a [NUM_PORTS];
   logic [DEPTH_W-1:0]   lfd_a [NUM_PORTS];
   logic [NUM_PORTS-1:0] up_take, up_ok, dn_take, dn_ok;
   logic                 pkt_long, pkt_red;
   steer_e               steer;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign dep_a[p]   = q_depth[p*DEPTH_W +: DEPTH_W];
      assign lfd_a[p]   = lf_depth[p*DEPTH_W +: DEPTH_W];
      assign up_take[p] = pkt_valid && !pkt_long && redirect_on[p] && (pkt_port == PORT_W'(p));
      assign dn_take[p] = dn_valid && (dn_port == PORT_W'(p));

      rdr_port_rule #(.DEPTH_W(DEPTH_W), .REDIR_TH(REDIR_TH)) u_rule (
         .clk(clk), .rst_n(rst_n), .depth(dep_a[p]), .drained(buf_empty[p]),
         .on(redirect_on[p]));

      rdr_token_bucket #(.RATE(UP_RATE), .MAX(UP_BURST), .LEN_W(LEN_W), .TOK_W(TOK_W)) u_up (
         .clk(clk), .rst_n(rst_n), .take(up_take[p]), .len(pkt_len), .ok(up_ok[p]));

      rdr_token_bucket #(.RATE(RATE), .MAX(BURST), .LEN_W(LEN_W), .TOK_W(TOK_W)) u_dn (
         .clk(clk), .rst_n(rst_n), .take(dn_take[p]), .len(dn_len), .ok(dn_ok[p]));
   end

   rdr_flow_meter #(.NUM_FLOWS(NUM_FLOWS), .FLOW_W(FLOW_W), .LEN_W(LEN_W),
                    .LF_BYTES(LF_BYTES), .CNT_W(CNT_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .valid(pkt_valid), .flow(pkt_flow), .len(pkt_len),
      .long_o(long_flow));

   assign pkt_long  = long_flow[pkt_flow];
   assign pkt_red   = redirect_on[pkt_port];
   assign dn_accept = dn_valid && dn_ok[dn_port];

   always_comb begin
      if (pkt_long)
         steer = (lfd_a[pkt_port] < DEPTH_W'(LF_CAP)) ? DST_LONG : DST_DROP;
      else if (pkt_red)
         steer = up_ok[pkt_port] ? DST_UP : DST_DROP;
      else
         steer = (dep_a[pkt_port] < DEPTH_W'(Q_LIMIT)) ? DST_LOCAL : DST_DROP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_dest  <= DST_LOCAL;
      end else begin
         dec_valid <= pkt_valid;
         if (pkt_valid) dec_dest <= steer;
      end
   end

   p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid |=> dec_valid);
   p_long_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && long_flow[pkt_flow] && lfd_a[pkt_port] < DEPTH_W'(LF_CAP))
      |=> (dec_dest == DST_LONG));
   p_drop_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid && !long_flow[pkt_flow] && !redirect_on[pkt_port] &&
       dep_a[pkt_port] >= DEPTH_W'(Q_LIMIT)) |=> (dec_dest == DST_DROP));
endmodule

// File: tb/burst_redirector_bench.sv
module burst_redirector_bench;
   localparam int NP = 4, NF = 8, DW = 8, QL = 100, TH = 80, LC = 50;
   localparam int LFB = 3000, LW = 11, RT = 64, BU = 2048;
   localparam int CSAT = (1 << ($clog2(LFB + 1) + 1)) - 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [NP*DW-1:0] q_depth, lf_depth;
   logic [NP-1:0]    buf_empty;
   logic             pkt_valid, dn_valid;
   logic [1:0]       pkt_port, dn_port;
   logic [2:0]       pkt_flow;
   logic [LW-1:0]    pkt_len, dn_len;
   logic             dec_valid, dn_accept;
   logic [1:0]       dec_dest;
   logic [NP-1:0]    redirect_on;
   logic [NF-1:0]    long_flow;

   burst_redirector #(.NUM_PORTS(NP), .NUM_FLOWS(NF), .DEPTH_W(DW), .Q_LIMIT(QL),
      .REDIR_TH(TH), .LF_CAP(LC), .LF_BYTES(LFB), .LEN_W(LW), .RATE(RT), .BURST(BU))
   u_burst_redirector (.*);

   always #4 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cyc_n = 0;
   int dep [NP], lfd [NP];
   bit emp [NP];
   bit m_red [NP];
   int m_up [NP], m_dn [NP], m_cnt [NF];

   task automatic chk(input bit good, input string tag, input int got, input int exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
      end
   endtask

   function automatic int refill(input int t, input int rate, input int mx);
      return (t + rate > mx) ? mx : t + rate;
   endfunction

   function automatic bit lflag(input int f);
      return m_cnt[f] > LFB;
   endfunction

   task automatic model_reset();
      for (int p = 0; p < NP; p++) begin
         m_red[p] = 0; m_up[p] = 2*BU; m_dn[p] = BU;
      end
      for (int f = 0; f < NF; f++) m_cnt[f] = 0;
   endtask

   task automatic cyc(input bit pv, input int pp, input int pf, input int pl,
                      input bit dv, input int dp, input int dl);
      int exp_d; bit up_try, up_ok, dn_ok; string tag;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         q_depth[p*DW +: DW] = DW'(dep[p]);
         lf_depth[p*DW +: DW] = DW'(lfd[p]);
         buf_empty[p] = emp[p];
      end
      pkt_valid = pv; pkt_port = 2'(pp); pkt_flow = 3'(pf); pkt_len = LW'(pl);
      dn_valid = dv; dn_port = 2'(dp); dn_len = LW'(dl);
      #1;
      dn_ok = dv && (m_dn[dp] >= dl);
      chk(dn_accept == dn_ok, "R7 downward accept", dn_accept, dn_ok);
      up_try = 0; up_ok = 0; exp_d = 0; tag = "R2 local path";
      if (pv) begin
         if (lflag(pf)) begin
            exp_d = (lfd[pp] < LC) ? 2 : 3; tag = "R5 long-flow path";
         end else if (m_red[pp]) begin
            up_try = 1; up_ok = (m_up[pp] >= pl);
            exp_d = up_ok ? 1 : 3; tag = "R6 upward path";
         end else begin
            exp_d = (dep[pp] < QL) ? 0 : 3;
         end
      end
      for (int p = 0; p < NP; p++) begin
         m_up[p] = refill(m_up[p] - ((up_try && up_ok && p == pp) ? pl : 0), 2*RT, 2*BU);
         m_dn[p] = refill(m_dn[p] - ((dn_ok && p == dp) ? dl : 0), RT, BU);
         if (dep[p] > TH) m_red[p] = 1;
         else if (emp[p]) m_red[p] = 0;
      end
      if (pv) m_cnt[pf] = (m_cnt[pf] + pl > CSAT) ? CSAT : m_cnt[pf] + pl;
      @(posedge clk); #1;
      chk(dec_valid == pv, "R9 decision valid", dec_valid, pv);
      if (pv) chk(dec_dest == 2'(exp_d), tag, dec_dest, exp_d);
      for (int p = 0; p < NP; p++)
         chk(redirect_on[p] == m_red[p], "R1 R3 redirect rule", redirect_on[p], m_red[p]);
      for (int f = 0; f < NF; f++)
         chk(long_flow[f] == lflag(f), "R4 long flag", long_flow[f], lflag(f));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog", cyc_n, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   always @(posedge clk) cyc_n++;

   initial begin
      void'($urandom(32'd4242));
      for (int p = 0; p < NP; p++) begin dep[p] = 10; lfd[p] = 0; emp[p] = 1; end
      q_depth = '0; lf_depth = '0; buf_empty = '1;
      pkt_valid = 0; pkt_port = 0; pkt_flow = 0; pkt_len = 0;
      dn_valid = 0; dn_port = 0; dn_len = 0;
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      // R8 reset state
      chk(dec_valid == 0, "R8 reset valid", dec_valid, 0);
      chk(redirect_on == '0, "R8 reset rules", redirect_on, 0);
      chk(long_flow == '0, "R8 reset long flags", long_flow, 0);
      @(negedge clk); rst_n = 1;
      // R1 headroom: crossing cycle stays local, then upward
      dep[0] = 81; emp[0] = 0;
      cyc(1, 0, 0, 100, 0, 0, 0);
      cyc(1, 0, 0, 100, 0, 0, 0);
      // R2 hard limit before any rule exists
      dep[1] = 100;
      cyc(1, 1, 1, 64, 0, 0, 0);
      dep[1] = 5;
      cyc(1, 1, 1, 64, 0, 0, 0);
      // R3 rule held while buffer not empty, then cleared
      dep[0] = 10;
      repeat (3) cyc(1, 0, 2, 200, 0, 0, 0);
      emp[0] = 1;
      cyc(0, 0, 0, 0, 0, 0, 0);
      cyc(1, 0, 2, 200, 0, 0, 0);
      // R4 / R5 promotion overrides redirect, cap drops
      repeat (4) cyc(1, 2, 5, 1000, 0, 0, 0);
      dep[2] = 95; emp[2] = 0;
      cyc(1, 2, 5, 500, 0, 0, 0);
      cyc(1, 2, 5, 500, 0, 0, 0);
      lfd[2] = 50;
      cyc(1, 2, 5, 500, 0, 0, 0);
      lfd[2] = 49;
      cyc(1, 2, 5, 500, 0, 0, 0);
      // R6 upward bucket exhaustion
      dep[3] = 90; emp[3] = 0;
      cyc(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 6; k++) cyc(1, 3, (k % 2) ? 3 : 4, 1500, 0, 0, 0);
      // R7 downward pacing
      for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 1, 1, 2000);
      // mixed random traffic
      for (int k = 0; k < 4000; k++) begin
         for (int p = 0; p < NP; p++) begin
            dep[p] = ($urandom % 8 == 0) ? 70 + $urandom % 40 : $urandom % 90;
            lfd[p] = 40 + $urandom % 15;
            emp[p] = ($urandom % 3 != 0);
         end
         cyc($urandom % 4 != 0, $urandom % NP, $urandom % NF, 1 + $urandom % 1500,
             $urandom % 2, $urandom % NP, 1 + $urandom % 2047);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule